// File: doc/BRIEF.md
# Trigger Window Watchdog

The block supervises a microcontroller by watching a trigger line for rising edges. Its time base is a triangle oscillator, built as a counter that climbs by a fixed step to an upper turn point and then descends to a lower turn point. Each arrival at the upper point is one oscillator period and advances a period count. If the count reaches the window length before a trigger edge clears it, the block pulls its active-low interrupt request low. The request then stays low for a fixed number of further periods, after which the count wraps to zero and the request is released.

A trigger edge also pulls the oscillator into step with the software. An edge seen while the ramp climbs turns it downward at once. An edge seen while the ramp descends leaves the direction alone. While the request is low the block ignores both trigger edges and the enable input, so a full low pulse is always delivered. With enable low and no low phase running, the ramp and the count are held at zero. Debug outputs show the period count and the ramp direction.

Top module: `trig_window_watchdog`

## Requirements
- R1: After synchronous reset, nmi_n is 1, dbg_count is 0 and dbg_rising is 1 (ramp at zero, climbing).
- R2: While running, the ramp climbs by RAMP_STEP per clock until it would reach RAMP_HI, which it then takes while turning downward. It descends by RAMP_STEP until it would reach RAMP_LO, which it then takes while turning upward. dbg_rising is 1 while climbing and 0 while descending.
- R3: Each clock in which the climbing ramp reaches RAMP_HI adds one to dbg_count.
- R4: The period that brings dbg_count from WIN_PERIODS-1 to WIN_PERIODS drives nmi_n to 0 in the same registered update.
- R5: A trigger edge while nmi_n is 1 and enable is 1 clears dbg_count on the next clock.
- R6: A trigger edge while the ramp climbs turns it downward on the next clock (dbg_rising 0). The ramp level holds for that clock and no period is counted. This holds even in the clock where the ramp would have reached RAMP_HI.
- R7: A trigger edge while the ramp descends leaves the ramp direction unchanged.
- R8: During the low phase, periods keep counting. The period taken at count WIN_PERIODS+LOW_PERIODS-1 sets dbg_count to 0 and nmi_n to 1, so nmi_n stays low for exactly LOW_PERIODS periods.
- R9: While nmi_n is 0, trigger edges clear nothing and do not alter the ramp direction.
- R10: While nmi_n is 0, the enable input is ignored. A disable takes effect only on the clock after the release.
- R11: While enable is 0 outside a low phase, the ramp is held at zero climbing, dbg_count is 0 and nmi_n is 1. After enable returns to 1, the ramp restarts from zero.
- R12: An edge is a 0-to-1 change of trig between consecutive clocks. Holding trig high for several clocks counts as one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Watchdog on (1) or off (0) |
| trig | input | 1 | Trigger line from software, already synchronous to clk |
| nmi_n | output | 1 | Active-low interrupt request, registered |
| dbg_count | output | $clog2(WIN_PERIODS+LOW_PERIODS) | Oscillator period count |
| dbg_rising | output | 1 | Ramp direction, 1 when climbing |

## Verification
The sharpest collision is a trigger edge that lands in the same clock as the final period of the window. In that clock the climbing ramp would both reach its upper point and time out. The bench waits one clock short of the timeout and then pulses the trigger. It expects nmi_n to stay high, the count to return to zero and the ramp to turn downward, because the edge must win over the period tick. A second collision is the release period of the low phase with enable already low. The bench checks that the release happens first and that the idle state appears only one clock later.

// File: rtl/twwd_pkg.sv
`timescale 1ns/1ps
package twwd_pkg;
  typedef enum logic {
    DIR_FALL = 1'b0,
    DIR_RISE = 1'b1
  } ramp_dir_e;
endpackage

// File: rtl/twwd_edge.sv
`timescale 1ns/1ps
// Rising-edge detector on an already synchronous trigger line.
module twwd_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig_in;
  end

  assign rise = sig_in & ~prev_q;

  // An edge can never be reported on two consecutive clocks
  assert_single_edge_R12: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/twwd_ramp.sv
`timescale 1ns/1ps
// Triangle oscillator: up/down counter between two turn points.
module twwd_ramp
  import twwd_pkg::*;
#(
  parameter int RAMP_W    = 8,
  parameter int RAMP_LO   = 20,
  parameter int RAMP_HI   = 200,
  parameter int RAMP_STEP = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      run,
  input  logic      sync_edge,
  output ramp_dir_e dir,
  output logic      tick
);
  localparam logic [RAMP_W-1:0] HI_C    = RAMP_W'(RAMP_HI);
  localparam logic [RAMP_W-1:0] LO_C    = RAMP_W'(RAMP_LO);
  localparam logic [RAMP_W-1:0] STEP_C  = RAMP_W'(RAMP_STEP);
  localparam logic [RAMP_W-1:0] HI_TURN = RAMP_W'(RAMP_HI - RAMP_STEP);
  localparam logic [RAMP_W-1:0] LO_TURN = RAMP_W'(RAMP_LO + RAMP_STEP);

  logic [RAMP_W-1:0] level_q;
  ramp_dir_e         dir_q;
  logic              flip;

  assign flip = run && sync_edge && (dir_q == DIR_RISE);
  assign tick = run && !flip && (dir_q == DIR_RISE) && (level_q >= HI_TURN);
  assign dir  = dir_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      level_q <= '0;
      dir_q   <= DIR_RISE;
    end else if (flip) begin
      dir_q   <= DIR_FALL;
    end else if (dir_q == DIR_RISE) begin
      if (level_q >= HI_TURN) begin
        level_q <= HI_C;
        dir_q   <= DIR_FALL;
      end else begin
        level_q <= level_q + STEP_C;
      end
    end else begin
      if (level_q <= LO_TURN) begin
        level_q <= LO_C;
        dir_q   <= DIR_RISE;
      end else begin
        level_q <= level_q - STEP_C;
      end
    end
  end

  assert_ramp_bounds_R2: assert property (@(posedge clk) disable iff (rst)
    level_q <= HI_C);
  assert_flip_holds_R6: assert property (@(posedge clk) disable iff (rst)
    flip |=> (dir_q == DIR_FALL) && $stable(level_q));
  assert_fall_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (run && sync_edge && dir_q == DIR_FALL && level_q > LO_TURN) |=> dir_q == DIR_FALL);
endmodule

// File: rtl/twwd_supervisor.sv
`timescale 1ns/1ps
// Period counter, timeout decision and guaranteed low phase.
module twwd_supervisor #(
  parameter int WIN_PERIODS = 48,
  parameter int LOW_PERIODS = 16,
  localparam int CNT_W = $clog2(WIN_PERIODS + LOW_PERIODS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             sync_edge,
  input  logic             tick,
  output logic             armed,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] WIN_C  = CNT_W'(WIN_PERIODS - 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(WIN_PERIODS + LOW_PERIODS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             nmi_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      nmi_q <= 1'b1;
    end else if (sync_edge && nmi_q) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q == LAST_C) begin
        cnt_q <= '0;
        nmi_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == WIN_C) nmi_q <= 1'b0;
      end
    end
  end

  assign armed = nmi_q;
  assign count = cnt_q;

  assert_low_means_expired_R4: assert property (@(posedge clk) disable iff (rst)
    !nmi_q |-> cnt_q > WIN_C);
  assert_edge_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (run && sync_edge && nmi_q) |=> cnt_q == '0);
  assert_release_R8: assert property (@(posedge clk) disable iff (rst)
    (!nmi_q && tick && cnt_q == LAST_C) |=> (nmi_q && cnt_q == '0));
  assert_edges_masked_R9: assert property (@(posedge clk) disable iff (rst)
    (!nmi_q && !tick) |=> $stable(cnt_q));
  assert_low_kept_R10: assert property (@(posedge clk) disable iff (rst)
    (!nmi_q && !tick) |=> !nmi_q);
endmodule

// File: rtl/trig_window_watchdog.sv
`timescale 1ns/1ps
module trig_window_watchdog
  import twwd_pkg::*;
#(
  parameter int RAMP_W      = 8,
  parameter int RAMP_LO     = 20,
  parameter int RAMP_HI     = 200,
  parameter int RAMP_STEP   = 4,
  parameter int WIN_PERIODS = 48,
  parameter int LOW_PERIODS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic trig,
  output logic nmi_n,
  output logic [$clog2(WIN_PERIODS+LOW_PERIODS)-1:0] dbg_count,
  output logic dbg_rising
);
  localparam int CNT_W = $clog2(WIN_PERIODS + LOW_PERIODS);

  logic             edge_raw;
  logic             edge_live;
  logic             armed;
  logic             run;
  logic             tick;
  ramp_dir_e        dir;
  logic [CNT_W-1:0] count;

  // The low phase keeps the block running whatever enable says
  assign run       = enable | ~armed;
  assign edge_live = edge_raw & armed;

  twwd_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_in (trig),
    .rise   (edge_raw)
  );

  twwd_ramp #(
    .RAMP_W    (RAMP_W),
    .RAMP_LO   (RAMP_LO),
    .RAMP_HI   (RAMP_HI),
    .RAMP_STEP (RAMP_STEP)
  ) u_ramp (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .sync_edge (edge_live),
    .dir       (dir),
    .tick      (tick)
  );

  twwd_supervisor #(
    .WIN_PERIODS (WIN_PERIODS),
    .LOW_PERIODS (LOW_PERIODS)
  ) u_sup (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .sync_edge (edge_live),
    .tick      (tick),
    .armed     (armed),
    .count     (count)
  );

  assign nmi_n      = armed;
  assign dbg_count  = count;
  assign dbg_rising = (dir == DIR_RISE);

  assert_idle_state_R11: assert property (@(posedge clk) disable iff (rst)
    (!enable && nmi_n) |=> (dbg_count == '0 && dbg_rising && nmi_n));
endmodule

// File: tb/test_trig_window_watchdog.sv
`timescale 1ns/1ps
module test_trig_window_watchdog;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b1;
  logic       trig = 1'b0;
  logic       nmi_n;
  logic [5:0] dbg_count;
  logic       dbg_rising;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  // Short ramp: climbs 0..4, descends 4..0, period 8 clocks, first tick at clock 4
  trig_window_watchdog #(
    .RAMP_W(8), .RAMP_LO(0), .RAMP_HI(4), .RAMP_STEP(1),
    .WIN_PERIODS(48), .LOW_PERIODS(16)
  ) i_trig_window_watchdog (
    .clk(clk), .rst(rst), .enable(enable), .trig(trig),
    .nmi_n(nmi_n), .dbg_count(dbg_count), .dbg_rising(dbg_rising)
  );

  // {clocks after reset, count, rising, nmi_n}
  localparam int VEC_N = 9;
  localparam int VEC [VEC_N][4] = '{
    '{0,   0,  1, 1},
    '{3,   0,  1, 1},
    '{4,   1,  0, 1},
    '{8,   1,  1, 1},
    '{12,  2,  0, 1},
    '{379, 47, 1, 1},
    '{380, 48, 0, 0},
    '{507, 63, 1, 0},
    '{508, 0,  0, 1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; trig = 1'b0; enable = 1'b1;
    idle(3);
    rst = 1'b0;
  endtask

  task automatic pulse();
    trig = 1'b1;
    idle(1);
    trig = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    // Table walk: R1 reset, R2 direction, R3 counting, R4 timeout, R8 release
    for (int v = 0; v < VEC_N; v++) begin
      do_reset();
      idle(VEC[v][0]);
      check("R1/R3 count vector", int'(dbg_count), VEC[v][1]);
      check("R2 direction vector", int'(dbg_rising), VEC[v][2]);
      check("R4/R8 nmi vector", int'(nmi_n), VEC[v][3]);
    end

    // R6: edge while climbing turns the ramp at level 2
    do_reset(); idle(2); pulse();
    check("R6 dir after rising edge", int'(dbg_rising), 0);
    check("R5 count cleared", int'(dbg_count), 0);
    idle(5);
    check("R6 back to climbing", int'(dbg_rising), 1);
    idle(1);
    check("R6 shifted tick", int'(dbg_count), 1);

    // R7: edge while descending keeps direction, R5 clears count 1
    do_reset(); idle(5); pulse();
    check("R7 dir kept", int'(dbg_rising), 0);
    check("R5 count cleared on fall", int'(dbg_count), 0);
    idle(2);
    check("R7 bottom turn", int'(dbg_rising), 1);
    idle(4);
    check("R7 next tick", int'(dbg_count), 1);

    // R12: trig held high four clocks is one edge
    do_reset(); idle(2);
    trig = 1'b1; idle(4);
    check("R12 level not re-edge", int'(dbg_rising), 1);
    trig = 1'b0; idle(1);
    check("R12 still climbing", int'(dbg_rising), 1);

    // Collision: edge in the clock of the window's last period (R6 wins over R4)
    do_reset(); idle(379); pulse();
    check("R6 collision nmi", int'(nmi_n), 1);
    check("R6 collision count", int'(dbg_count), 0);
    check("R6 collision dir", int'(dbg_rising), 0);

    // R9: edge during low phase while climbing is masked
    do_reset(); idle(384); pulse();
    check("R9 masked dir", int'(dbg_rising), 1);
    check("R9 masked count", int'(dbg_count), 48);
    idle(123);
    check("R8 release nmi", int'(nmi_n), 1);
    check("R8 release count", int'(dbg_count), 0);

    // R10: disable during low phase ignored until release
    do_reset(); idle(380);
    enable = 1'b0;
    idle(20);
    check("R10 nmi held", int'(nmi_n), 0);
    check("R10 count runs", int'(dbg_count), 50);
    idle(108);
    check("R10 release first", int'(nmi_n), 1);
    check("R10 release dir", int'(dbg_rising), 0);
    idle(1);
    check("R10 then idle dir", int'(dbg_rising), 1);
    check("R10 then idle count", int'(dbg_count), 0);
    idle(11);
    enable = 1'b1;
    idle(3);
    check("R11 restart from zero", int'(dbg_count), 0);
    idle(1);
    check("R11 restart tick", int'(dbg_count), 1);

    // R11: disable outside low phase, edges ignored while off
    do_reset(); idle(6);
    enable = 1'b0; idle(1);
    check("R11 count zero", int'(dbg_count), 0);
    check("R11 climbing", int'(dbg_rising), 1);
    check("R11 nmi high", int'(nmi_n), 1);
    idle(2); pulse(); idle(2);
    check("R11 edge ignored", int'(dbg_rising), 1);
    enable = 1'b1;
    idle(3);
    check("R11 re-enable no tick yet", int'(dbg_count), 0);
    idle(1);
    check("R11 re-enable tick", int'(dbg_count), 1);

    done = 1'b1;
    finish_run();
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end
endmodule